// File: doc/BRIEF.md
# Banked Internal Memory Address Decoder

This block sits between the load/store unit of a small 8-bit controller core and that core's memory targets. It takes one byte access per cycle and sends it to exactly one target: the special-function-register page, a 256-byte on-chip RAM page, the core's live general register file, or the external memory bus. The four-bank general register file is overlaid on the top of the RAM page. The eight-byte slot that the overlay covers moves with the current bank selection, so the same RAM address can reach storage under one bank and a live register under another.

Accesses come in three kinds. Ordinary data accesses use the full 16-bit address. When the wide-address mode is on, they extend external addresses with a 4-bit bank nibble, taken from the main nibble source or, for alternate-bank accesses, from the alternate source. Short direct accesses carry only an 8-bit operand. That operand wraps over the upper RAM area and the SFR page. Plain accesses (opcode fetch, stack push and pop) never get the bank extension. Reads are combinational: the return mux selects register file, RAM, SFR or external data in the same cycle. Writes to RAM take effect at the next rising clock edge.

Top module: `bank_mem_decoder`

## Requirements
- R1: With access kind 00 (data) or 10 (plain), an address whose upper byte is 0xFF selects the SFR page: the SFR offset equals the low address byte and a read returns `sfr_rdata`.
- R2: With kind 00 or 10, an address whose upper byte is 0xFE selects on-chip RAM at the low address byte when that offset is outside the active register slot. A written byte is returned by later reads of the same offset.
- R3: With kind 00 or 10, any address below 0xFE00 selects the external bus: `ext_addr[15:0]` equals the address and a read returns `ext_rdata`.
- R4: The active register slot spans RAM offsets from 0xF8 − 8×`bank_sel` up to that value + 7 (bank 0: 0xF8–0xFF, bank 3: 0xE0–0xE7). Offsets in other banks' slots are ordinary RAM.
- R5: A RAM-page access inside the active slot goes to the register file with `gpr_idx` = offset & 7 (index order X, A, C, B, E, D, L, H = 0..7), and a read returns `gpr_rdata`.
- R6: A write to the active slot updates only the register file. The RAM byte behind the slot keeps its previous value, which becomes visible after the bank selection changes.
- R7: With kind 01 (short), an operand in 0xE0–0xFF (taken from `req_addr[7:0]`) selects the SFR page at offset operand − 0xE0.
- R8: With kind 01, an operand below 0xE0 selects RAM offset operand + 0x20. R4 and R5 then apply to that offset.
- R9: With kind 00 and `ext_wide_en` high, `ext_addr[19:16]` equals `bank_nib` or, when `req_alt` is high, `bank_nib_alt`. With `ext_wide_en` low it is zero.
- R10: With kind 10, `ext_addr[19:16]` is zero whatever `ext_wide_en` is.
- R11: SFR and RAM page selection uses only the 16-bit address, so the wide-address mode never moves an access off those pages.
- R12: At most one target strobe is active in any cycle. With `req_valid` low no strobe is active and `rdata` is zero; `rdata` is also zero during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 00 data, 01 short direct, 10 plain (fetch/stack), 11 treated as plain |
| req_alt | input | 1 | Use alternate bank nibble |
| req_addr | input | 16 | Byte address, or operand in bits 7:0 for short kind |
| req_wdata | input | 8 | Write data |
| bank_sel | input | 2 | Active register bank |
| ext_wide_en | input | 1 | Wide external addressing mode |
| bank_nib | input | 4 | Main bank nibble |
| bank_nib_alt | input | 4 | Alternate bank nibble |
| rdata | output | 8 | Read data return |
| mem_wdata | output | 8 | Write data to all targets |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_off | output | 8 | SFR offset |
| sfr_rdata | input | 8 | SFR read data |
| gpr_we | output | 1 | Register file write strobe |
| gpr_idx | output | 3 | Register index |
| gpr_rdata | input | 8 | Register file read data at `gpr_idx` |
| ext_re | output | 1 | External read strobe |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | 20 | External address |
| ext_rdata | input | 8 | External read data |

## Verification
The hardest case to reach from the ports is a RAM byte that is hidden behind the register overlay. It has to be written while it is ordinary RAM, then the overlay must slide over it and be written, and then the overlay must slide away again before the old byte can be read. The bench first fills every RAM offset, choosing a bank that keeps the written offset outside the overlay. It then runs directed write/bank-switch/read sequences. Random traffic follows, with the bank changing freely. The short-operand wrap onto the overlay (operands 0xC0–0xDF) is targeted directly and also reached in the random mix.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_SFR  = 3'd1,
      TGT_RAM  = 3'd2,
      TGT_GPR  = 3'd3,
      TGT_EXT  = 3'd4
   } tgt_e;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'd0,
      KIND_SHORT = 2'd1,
      KIND_PLAIN = 2'd2,
      KIND_RSVD  = 2'd3
   } kind_e;
endpackage

// File: rtl/bmd_addr_map.sv
module bmd_addr_map
   import bmd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int OFF_W       = 8,
   parameter int NIB_W       = 4,
   parameter bit EXT_EN      = 1'b1,
   parameter int SFR_PAGE    = 'hFF,
   parameter int RAM_PAGE    = 'hFE,
   parameter int SHORT_SPLIT = 'hE0,
   parameter int SHORT_BIAS  = 'h20,
   localparam int EXT_W      = ADDR_W + NIB_W,
   localparam int PAGE_W     = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [1:0]        kind,
   input  logic              alt,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wide_en,
   input  logic [NIB_W-1:0]  nib_main,
   input  logic [NIB_W-1:0]  nib_alt,
   output tgt_e              page_tgt,
   output logic [OFF_W-1:0]  off,
   output logic [EXT_W-1:0]  ext_addr
);
   localparam logic [PAGE_W-1:0] SFR_P = PAGE_W'(SFR_PAGE);
   localparam logic [PAGE_W-1:0] RAM_P = PAGE_W'(RAM_PAGE);
   localparam logic [OFF_W-1:0]  SPLIT = OFF_W'(SHORT_SPLIT);
   localparam logic [OFF_W-1:0]  BIAS  = OFF_W'(SHORT_BIAS);

   logic [PAGE_W-1:0] page;
   logic [OFF_W-1:0]  lo;
   logic              is_short;

   assign page     = addr[ADDR_W-1:OFF_W];
   assign lo       = addr[OFF_W-1:0];
   assign is_short = (kind == KIND_SHORT);

   always_comb begin
      page_tgt = TGT_NONE;
      off      = lo;
      if (valid) begin
         if (is_short) begin
            if (lo >= SPLIT) begin
               page_tgt = TGT_SFR;
               off      = lo - SPLIT;
            end else begin
               page_tgt = TGT_RAM;
               off      = lo + BIAS;
            end
         end else if (page == SFR_P) begin
            page_tgt = TGT_SFR;
         end else if (page == RAM_P) begin
            page_tgt = TGT_RAM;
         end else begin
            page_tgt = TGT_EXT;
         end
      end
   end

   generate
      if (EXT_EN) begin : g_wide
         logic use_bank;
         assign use_bank = wide_en && (kind == KIND_DATA);
         assign ext_addr = {use_bank ? (alt ? nib_alt : nib_main) : {NIB_W{1'b0}}, addr};
      end else begin : g_narrow
         assign ext_addr = {{NIB_W{1'b0}}, addr};
      end
   endgenerate

   // R10: fetch/stack accesses never carry a bank nibble
   assert_plain_flat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && kind == KIND_PLAIN && page_tgt == TGT_EXT) |-> (ext_addr[EXT_W-1:ADDR_W] == '0));

   // R7/R8: the short window never leaves the internal pages
   assert_short_internal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_short) |-> (page_tgt == TGT_SFR || page_tgt == TGT_RAM));
endmodule

// File: rtl/bmd_bank_window.sv
module bmd_bank_window
   import bmd_pkg::*;
#(
   parameter int OFF_W  = 8,
   parameter int BANK_W = 2,
   parameter int REGS_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tgt_e              page_tgt,
   input  logic [OFF_W-1:0]  off,
   input  logic [BANK_W-1:0] bank,
   output tgt_e              tgt,
   output logic [REGS_W-1:0] gpr_idx
);
   localparam int SLOT_W   = OFF_W - REGS_W;
   localparam int TOP_SLOT = (1 << OFF_W) - (1 << REGS_W);

   logic [OFF_W-1:0] slot_base;
   logic             in_slot;

   assign slot_base = OFF_W'(TOP_SLOT) - (OFF_W'(bank) << REGS_W);
   assign in_slot   = (off[OFF_W-1:REGS_W] == slot_base[OFF_W-1:REGS_W]);
   assign gpr_idx   = off[REGS_W-1:0];

   always_comb begin
      tgt = page_tgt;
      if (page_tgt == TGT_RAM && in_slot) tgt = TGT_GPR;
   end

   // R4: register steering only happens inside the bank area at the top of RAM
   assert_gpr_in_bank_area_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_GPR) |-> (page_tgt == TGT_RAM &&
         off[OFF_W-1:REGS_W] >= SLOT_W'((TOP_SLOT >> REGS_W) - ((1 << BANK_W) - 1))));
endmodule

// File: rtl/bmd_ram.sv
module bmd_ram #(
   parameter int OFF_W  = 8,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << OFF_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [OFF_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/bmd_rdata_mux.sv
module bmd_rdata_mux
   import bmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  tgt_e              tgt,
   input  logic              rd,
   input  logic [DATA_W-1:0] gpr_d,
   input  logic [DATA_W-1:0] ram_d,
   input  logic [DATA_W-1:0] sfr_d,
   input  logic [DATA_W-1:0] ext_d,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (tgt)
            TGT_GPR: rdata = gpr_d;
            TGT_RAM: rdata = ram_d;
            TGT_SFR: rdata = sfr_d;
            TGT_EXT: rdata = ext_d;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
   import bmd_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int OFF_W      = 8,
   parameter int BANK_W     = 2,
   parameter int REGS_W     = 3,
   parameter int NIB_W      = 4,
   parameter bit EXT_EN     = 1'b1,
   localparam int EXT_W     = ADDR_W + NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_kind,
   input  logic              req_alt,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              ext_wide_en,
   input  logic [NIB_W-1:0]  bank_nib,
   input  logic [NIB_W-1:0]  bank_nib_alt,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              sfr_re,
   output logic              sfr_we,
   output logic [OFF_W-1:0]  sfr_off,
   input  logic [DATA_W-1:0] sfr_rdata,
   output logic              gpr_we,
   output logic [REGS_W-1:0] gpr_idx,
   input  logic [DATA_W-1:0] gpr_rdata,
   output logic              ext_re,
   output logic              ext_we,
   output logic [EXT_W-1:0]  ext_addr,
   input  logic [DATA_W-1:0] ext_rdata
);
   generate
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("bank_mem_decoder: ADDR_W must exceed OFF_W");
      end
      if (OFF_W < REGS_W + BANK_W) begin : g_bad_bank
         $error("bank_mem_decoder: register banks do not fit the RAM page");
      end
   endgenerate

   tgt_e             page_tgt;
   tgt_e             tgt;
   logic [OFF_W-1:0] off;
   logic [DATA_W-1:0] ram_rdata;
   logic             ram_we;
   logic             rd;
   logic             wr;

   assign rd = req_valid && !req_write;
   assign wr = req_valid &&  req_write;

   bmd_addr_map #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .NIB_W  (NIB_W),
      .EXT_EN (EXT_EN)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (req_valid),
      .kind     (req_kind),
      .alt      (req_alt),
      .addr     (req_addr),
      .wide_en  (ext_wide_en),
      .nib_main (bank_nib),
      .nib_alt  (bank_nib_alt),
      .page_tgt (page_tgt),
      .off      (off),
      .ext_addr (ext_addr)
   );

   bmd_bank_window #(
      .OFF_W  (OFF_W),
      .BANK_W (BANK_W),
      .REGS_W (REGS_W)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_tgt (page_tgt),
      .off      (off),
      .bank     (bank_sel),
      .tgt      (tgt),
      .gpr_idx  (gpr_idx)
   );

   assign ram_we = wr && (tgt == TGT_RAM);

   bmd_ram #(
      .OFF_W  (OFF_W),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (off),
      .wdata (req_wdata),
      .rdata (ram_rdata)
   );

   bmd_rdata_mux #(.DATA_W(DATA_W)) u_mux (
      .tgt   (tgt),
      .rd    (rd),
      .gpr_d (gpr_rdata),
      .ram_d (ram_rdata),
      .sfr_d (sfr_rdata),
      .ext_d (ext_rdata),
      .rdata (rdata)
   );

   assign mem_wdata = req_wdata;
   assign sfr_off   = off;
   assign sfr_re    = rd && (tgt == TGT_SFR);
   assign sfr_we    = wr && (tgt == TGT_SFR);
   assign gpr_we    = wr && (tgt == TGT_GPR);
   assign ext_re    = rd && (tgt == TGT_EXT);
   assign ext_we    = wr && (tgt == TGT_EXT);

   // R12: one target per access
   assert_single_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sfr_re, sfr_we, ext_re, ext_we, gpr_we, ram_we}));

   // R12: idle cycles are silent
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!(sfr_re || sfr_we || ext_re || ext_we || gpr_we || ram_we) && rdata == '0));

   // R6: a register write never reaches the RAM storage
   assert_overlay_spares_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_we |-> !ram_we);

   // R11: internal pages stay internal in wide mode
   assert_pages_internal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != KIND_SHORT && req_addr[ADDR_W-1:OFF_W+1] == '1) |-> !(ext_re || ext_we));
endmodule

// File: tb/test_bank_mem_decoder.sv
module test_bank_mem_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_alt = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [1:0]  bank_sel = 2'd0;
   logic        ext_wide_en = 1'b0;
   logic [3:0]  bank_nib = 4'h0, bank_nib_alt = 4'h0;
   logic [7:0]  rdata, mem_wdata, sfr_off, sfr_rdata, gpr_rdata, ext_rdata;
   logic        sfr_re, sfr_we, gpr_we, ext_re, ext_we;
   logic [2:0]  gpr_idx;
   logic [19:0] ext_addr;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [7:0] stub_gpr [8];
   logic [7:0] exp_gpr  [8];
   logic [7:0] exp_ram  [256];

   always #5 clk = ~clk;

   always @(posedge clk) if (gpr_we) stub_gpr[gpr_idx] <= mem_wdata;
   assign gpr_rdata = stub_gpr[gpr_idx];
   assign sfr_rdata = sfr_off ^ 8'h5A;
   assign ext_rdata = ext_addr[7:0] ^ {ext_addr[19:16], ext_addr[19:16]};

   bank_mem_decoder i_bank_mem_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_kind(req_kind), .req_alt(req_alt), .req_addr(req_addr), .req_wdata(req_wdata),
      .bank_sel(bank_sel), .ext_wide_en(ext_wide_en), .bank_nib(bank_nib),
      .bank_nib_alt(bank_nib_alt), .rdata(rdata), .mem_wdata(mem_wdata),
      .sfr_re(sfr_re), .sfr_we(sfr_we), .sfr_off(sfr_off), .sfr_rdata(sfr_rdata),
      .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_rdata(gpr_rdata),
      .ext_re(ext_re), .ext_we(ext_we), .ext_addr(ext_addr), .ext_rdata(ext_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected routing, from the requirements. tgt: 0 none,1 sfr,2 ram,3 gpr,4 ext
   task automatic predict(input logic [1:0] kind, input logic [15:0] a, input logic [1:0] bk,
                          input logic wide, input logic alt, input logic [3:0] nm, input logic [3:0] na,
                          output int tgt, output logic [7:0] off, output logic [19:0] ea,
                          output string tag);
      logic [7:0] base;
      ea = 20'h0;
      if (kind == 2'd1) begin
         if (a[7:0] >= 8'hE0) begin tgt = 1; off = a[7:0] - 8'hE0; tag = "R7"; end
         else begin tgt = 2; off = a[7:0] + 8'h20; tag = "R8"; end
      end else if (a[15:8] == 8'hFF) begin
         tgt = 1; off = a[7:0]; tag = "R1";
      end else if (a[15:8] == 8'hFE) begin
         tgt = 2; off = a[7:0]; tag = "R2";
      end else begin
         tgt = 4; off = a[7:0];
         ea = {(kind == 2'd0 && wide) ? (alt ? na : nm) : 4'h0, a};
         tag = (kind == 2'd0) ? "R9" : "R10";
      end
      base = 8'hF8 - {3'd0, bk, 3'd0};
      if (tgt == 2 && off[7:3] == base[7:3]) begin
         tgt = 3;
         tag = (kind == 2'd1) ? "R8" : "R5";
      end
   endtask

   task automatic access(input logic [1:0] kind, input logic [15:0] a, input logic wr,
                         input logic [7:0] wd, input logic [1:0] bk, input logic wide,
                         input logic alt, input logic [3:0] nm, input logic [3:0] na,
                         input string force_tag);
      int tgt; logic [7:0] off; logic [19:0] ea; string tag;
      logic [4:0] exp_str; logic [7:0] exp_rd;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = a; req_write = wr; req_wdata = wd;
      bank_sel = bk; ext_wide_en = wide; req_alt = alt; bank_nib = nm; bank_nib_alt = na;
      #1;
      predict(kind, a, bk, wide, alt, nm, na, tgt, off, ea, tag);
      if (force_tag != "") tag = force_tag;
      exp_str = {tgt == 1 && !wr, tgt == 1 && wr, tgt == 4 && !wr, tgt == 4 && wr, tgt == 3 && wr};
      chk({tag, " strobes(R12)"}, {27'd0, sfr_re, sfr_we, ext_re, ext_we, gpr_we}, {27'd0, exp_str});
      if (tgt == 1) chk({tag, " sfr_off"}, {24'd0, sfr_off}, {24'd0, off});
      if (tgt == 3) chk({tag, " gpr_idx"}, {29'd0, gpr_idx}, {29'd0, off[2:0]});
      if (tgt == 4) chk({tag, " ext_addr"}, {12'd0, ext_addr}, {12'd0, ea});
      case (tgt)
         1: exp_rd = off ^ 8'h5A;
         2: exp_rd = exp_ram[off];
         3: exp_rd = exp_gpr[off[2:0]];
         default: exp_rd = ea[7:0] ^ {ea[19:16], ea[19:16]};
      endcase
      if (wr) exp_rd = 8'h00;
      chk({tag, " rdata"}, {24'd0, rdata}, {24'd0, exp_rd});
      if (wr && tgt == 2) exp_ram[off] = wd;
      if (wr && tgt == 3) exp_gpr[off[2:0]] = wd;
   endtask

   task automatic idle_check();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b1; req_addr = 16'hFEF8; #1;
      chk("R12 idle strobes", {27'd0, sfr_re, sfr_we, ext_re, ext_we, gpr_we}, 32'd0);
      chk("R12 idle rdata", {24'd0, rdata}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin stub_gpr[i] = 8'h0; exp_gpr[i] = 8'h0; end
      for (int i = 0; i < 256; i++) exp_ram[i] = 8'h0;
      void'($urandom(32'd20250706));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_check();

      // Fill RAM through a bank whose slot avoids the target offset (R2)
      for (int i = 0; i < 256; i++)
         access(2'd0, 16'hFE00 | 16'(i), 1'b1, 8'(i * 7 + 3), (i >= 8'hF8) ? 2'd3 : 2'd0,
                1'b0, 1'b0, 4'h0, 4'h0, "R2");
      access(2'd0, 16'hFE41, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R2");

      // Slot position per bank (R4) and register index order (R5)
      for (int b = 0; b < 4; b++)
         for (int o = 8'hE0; o < 256; o += 3)
            access(2'd0, 16'hFE00 | 16'(o), 1'b0, 8'h0, 2'(b), 1'b0, 1'b0, 4'h0, 4'h0, "R4");
      access(2'd0, 16'hFEF3, 1'b1, 8'h3C, 2'd1, 1'b0, 1'b0, 4'h0, 4'h0, "R5");
      access(2'd0, 16'hFEF3, 1'b0, 8'h0,  2'd1, 1'b0, 1'b0, 4'h0, 4'h0, "R5");

      // Overlay write leaves RAM behind it untouched (R6)
      access(2'd0, 16'hFEF9, 1'b1, 8'hA5, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R6");
      access(2'd0, 16'hFEF9, 1'b0, 8'h0,  2'd3, 1'b0, 1'b0, 4'h0, 4'h0, "R6");
      access(2'd0, 16'hFEF9, 1'b0, 8'h0,  2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R6");

      // Short window edges (R7, R8)
      access(2'd1, 16'h12E0, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 4'h0, 4'h0, "R7");
      access(2'd1, 16'h00FF, 1'b1, 8'h11, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R7");
      access(2'd1, 16'h00DF, 1'b0, 8'h0, 2'd2, 1'b0, 1'b0, 4'h0, 4'h0, "R8");
      access(2'd1, 16'h00D8, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R8");
      access(2'd1, 16'h0000, 1'b1, 8'h77, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R8");
      access(2'd0, 16'hFE20, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, "R8");

      // External and wide mode (R3, R9, R10, R11)
      access(2'd0, 16'hFDFF, 1'b0, 8'h0, 2'd0, 1'b0, 1'b0, 4'h9, 4'h6, "R3");
      access(2'd0, 16'h0000, 1'b1, 8'h5, 2'd0, 1'b0, 1'b0, 4'h9, 4'h6, "R3");
      access(2'd0, 16'h8123, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 4'h9, 4'h6, "R9");
      access(2'd0, 16'h8123, 1'b0, 8'h0, 2'd0, 1'b1, 1'b1, 4'h9, 4'h6, "R9");
      access(2'd2, 16'h8123, 1'b0, 8'h0, 2'd0, 1'b1, 1'b1, 4'h9, 4'h6, "R10");
      access(2'd0, 16'hFF10, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 4'hF, 4'hF, "R11");
      access(2'd0, 16'hFE10, 1'b0, 8'h0, 2'd0, 1'b1, 1'b1, 4'hF, 4'hF, "R11");
      access(2'd2, 16'hFF80, 1'b0, 8'h0, 2'd0, 1'b1, 1'b0, 4'h3, 4'h3, "R1");
      idle_check();

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a; logic [1:0] k; int sel;
         sel = int'($urandom_range(0, 3));
         case (sel)
            0: a = 16'hFF00 | 16'($urandom_range(0, 255));
            1: a = 16'hFE00 | 16'($urandom_range(0, 255));
            2: a = 16'hFEC0 + 16'($urandom_range(0, 63));
            default: a = 16'($urandom());
         endcase
         k = 2'($urandom_range(0, 2));
         access(k, a, 1'($urandom()), 8'($urandom()), 2'($urandom()), 1'($urandom()),
                1'($urandom()), 4'($urandom()), 4'($urandom()), "");
         if (n % 500 == 0) idle_check();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule